// File: doc/BRIEF.md
# ASN-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations in a fully associative array of `DEPTH` slots. Each slot holds a virtual page tag, a physical page number, an address-space number (ASN), a global flag that lets the entry match in any address space, a read-enable mask and a write-enable mask with one bit per access mode, a fault-on-read flag, a fault-on-write flag and a valid bit. A combinational lookup port compares the requested page and the current ASN against every slot. It returns the lowest matching slot together with that slot's fields.

New translations enter through an insert port. An insert always writes the slot named by a rotating next-victim pointer, whatever that slot holds, and the pointer then moves on. Three flush operations remove stale state. One clears everything. One drops only the entries that are not global, as on an address-space switch. One drops the entries that match a given page and ASN. An index port shows the slot at the pointer and can step the pointer without inserting. Page walking, permission decisions and fault reporting belong to the surrounding logic.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no lookup hits and `idx_ptr_o` is 0.
- R2: A lookup hits only on a valid slot whose tag equals `lk_vpn_i` and whose global bit is set or whose stored ASN equals `lk_asn_i`. The hit and the slot's PPN, mode masks, fault flags and global bit appear combinationally in the same cycle. On a miss, `lk_ppn_o` reads 0.
- R3: `ins_valid_i` writes the slot at the pointer on the next clock edge, overwriting any valid entry there. The tag is `ins_vaddr_i[VA_W-1:OFS_W]` and the slot is marked valid. The pointer then advances by one.
- R4: The pointer wraps from `DEPTH-1` (47 by default) to 0.
- R5: `flush_op_i`=1 clears every valid bit and sets the pointer to 0. In that cycle it overrides any insert and any pointer advance.
- R6: `flush_op_i`=2 invalidates every slot whose global bit is clear and leaves global slots untouched.
- R7: `flush_op_i`=3 invalidates every slot whose tag equals `flush_vpn_i` and that is either global or holds ASN `flush_asn_i`. Other slots are unaffected.
- R8: `idx_valid_o`, `idx_vpn_o` and `idx_ppn_o` show the slot at the pointer. `idx_adv_i` advances the pointer by one. When it coincides with an insert, the pointer still advances only once.
- R9: When several slots match a lookup, the lowest slot index is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_vpn_i | input | VPN_W | Lookup page number |
| lk_asn_i | input | ASN_W | Current address-space number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_W | Slot that hit |
| lk_ppn_o | output | PPN_W | Physical page of the hit slot |
| lk_rd_en_o | output | MODE_N | Read-enable mask of the hit slot |
| lk_wr_en_o | output | MODE_N | Write-enable mask of the hit slot |
| lk_fault_rd_o | output | 1 | Fault-on-read flag of the hit slot |
| lk_fault_wr_o | output | 1 | Fault-on-write flag of the hit slot |
| lk_global_o | output | 1 | Global flag of the hit slot |
| ins_valid_i | input | 1 | Insert strobe |
| ins_vaddr_i | input | VA_W | Virtual address of the new entry |
| ins_ppn_i | input | PPN_W | Physical page of the new entry |
| ins_asn_i | input | ASN_W | ASN of the new entry |
| ins_global_i | input | 1 | Global flag of the new entry |
| ins_rd_en_i | input | MODE_N | Read-enable mask of the new entry |
| ins_wr_en_i | input | MODE_N | Write-enable mask of the new entry |
| ins_fault_rd_i | input | 1 | Fault-on-read flag of the new entry |
| ins_fault_wr_i | input | 1 | Fault-on-write flag of the new entry |
| flush_op_i | input | 2 | 0 none, 1 all, 2 non-global, 3 by address |
| flush_vpn_i | input | VPN_W | Page for the address flush |
| flush_asn_i | input | ASN_W | ASN for the address flush |
| idx_adv_i | input | 1 | Step the pointer without inserting |
| idx_ptr_o | output | IDX_W | Next-victim pointer |
| idx_valid_o | output | 1 | Valid bit of the slot at the pointer |
| idx_vpn_o | output | VPN_W | Tag of the slot at the pointer |
| idx_ppn_o | output | PPN_W | PPN of the slot at the pointer |

## Verification
The assertions check, on every cycle:
- that the reported slot is the lowest match;
- that the pointer stays in range and steps with wrap on each insert;
- that after a full flush nothing hits and the pointer is 0;
- that after a non-global flush or an address flush, with no insert in the same cycle, no lookup can hit an entry that the flush should have removed.

Only the bench scenarios can show:
- that survivors keep their data;
- that an overwritten victim stops hitting;
- that the field values come back intact;
- that a full flush overrides a simultaneous insert;
- that a random mix of inserts, flushes and lookups agrees with an independent model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_ALL  = 2'd1,
    FL_PROC = 2'd2,
    FL_ADDR = 2'd3
  } flush_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 48,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [N-1:0]     vld_i,
  input  logic [N-1:0]     glb_i,
  input  logic [VPN_W-1:0] tag_i [N],
  input  logic [ASN_W-1:0] asn_i [N],
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [ASN_W-1:0] req_asn_i,
  output logic [N-1:0]     match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = vld_i[g] && (tag_i[g] == vpn_i) &&
                        (glb_i[g] || (asn_i[g] == req_asn_i));
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N = 48,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     match_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |match_i;

  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << idx_o) - N'(1);

  always_comb begin
    if (hit_o) begin
      assert_lowest_R9: assert (match_i[idx_o] && ((match_i & below_mask) == '0));
    end
  end
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int DEPTH = 48,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end
  assign ptr_o = ptr_q;

  assert_ptr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int VPN_W  = 30,
  parameter int OFS_W  = 13,
  parameter int PPN_W  = 27,
  parameter int ASN_W  = 8,
  parameter int MODE_N = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int VA_W  = VPN_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASN_W-1:0]  lk_asn_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [MODE_N-1:0] lk_rd_en_o,
  output logic [MODE_N-1:0] lk_wr_en_o,
  output logic              lk_fault_rd_o,
  output logic              lk_fault_wr_o,
  output logic              lk_global_o,
  input  logic              ins_valid_i,
  input  logic [VA_W-1:0]   ins_vaddr_i,
  input  logic [PPN_W-1:0]  ins_ppn_i,
  input  logic [ASN_W-1:0]  ins_asn_i,
  input  logic              ins_global_i,
  input  logic [MODE_N-1:0] ins_rd_en_i,
  input  logic [MODE_N-1:0] ins_wr_en_i,
  input  logic              ins_fault_rd_i,
  input  logic              ins_fault_wr_i,
  input  logic [1:0]        flush_op_i,
  input  logic [VPN_W-1:0]  flush_vpn_i,
  input  logic [ASN_W-1:0]  flush_asn_i,
  input  logic              idx_adv_i,
  output logic [IDX_W-1:0]  idx_ptr_o,
  output logic              idx_valid_o,
  output logic [VPN_W-1:0]  idx_vpn_o,
  output logic [PPN_W-1:0]  idx_ppn_o
);
  flush_op_e op;
  assign op = flush_op_e'(flush_op_i);

  logic [DEPTH-1:0]  vld_q, vld_d, glb_q, frd_q, fwr_q;
  logic [VPN_W-1:0]  tag_q [DEPTH];
  logic [ASN_W-1:0]  asn_q [DEPTH];
  logic [PPN_W-1:0]  ppn_q [DEPTH];
  logic [MODE_N-1:0] ren_q [DEPTH];
  logic [MODE_N-1:0] wen_q [DEPTH];

  logic [IDX_W-1:0] ptr;
  logic             ins_go, flush_all;
  logic [DEPTH-1:0] lk_match, fl_match;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;

  assign flush_all = (op == FL_ALL);
  assign ins_go    = ins_valid_i && !flush_all;

  tlb_victim_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (flush_all),
    .adv_i (ins_go || idx_adv_i),
    .ptr_o (ptr)
  );

  tlb_match #(.N(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .vld_i(vld_q), .glb_i(glb_q), .tag_i(tag_q), .asn_i(asn_q),
    .vpn_i(lk_vpn_i), .req_asn_i(lk_asn_i), .match_o(lk_match)
  );

  tlb_match #(.N(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .vld_i(vld_q), .glb_i(glb_q), .tag_i(tag_q), .asn_i(asn_q),
    .vpn_i(flush_vpn_i), .req_asn_i(flush_asn_i), .match_o(fl_match)
  );

  tlb_prio_enc #(.N(DEPTH)) u_prio (
    .match_i(lk_match), .hit_o(lk_hit), .idx_o(lk_idx)
  );

  // flush first, then the insert claims its slot
  always_comb begin
    unique case (op)
      FL_ALL:  vld_d = '0;
      FL_PROC: vld_d = vld_q & glb_q;
      FL_ADDR: vld_d = vld_q & ~fl_match;
      default: vld_d = vld_q;
    endcase
    if (ins_go) vld_d[ptr] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk_i) begin
    if (ins_go) begin
      tag_q[ptr] <= ins_vaddr_i[VA_W-1:OFS_W];
      asn_q[ptr] <= ins_asn_i;
      ppn_q[ptr] <= ins_ppn_i;
      ren_q[ptr] <= ins_rd_en_i;
      wen_q[ptr] <= ins_wr_en_i;
      glb_q[ptr] <= ins_global_i;
      frd_q[ptr] <= ins_fault_rd_i;
      fwr_q[ptr] <= ins_fault_wr_i;
    end
  end

  assign lk_hit_o      = lk_hit;
  assign lk_idx_o      = lk_idx;
  assign lk_ppn_o      = lk_hit ? ppn_q[lk_idx] : '0;
  assign lk_rd_en_o    = lk_hit ? ren_q[lk_idx] : '0;
  assign lk_wr_en_o    = lk_hit ? wen_q[lk_idx] : '0;
  assign lk_fault_rd_o = lk_hit && frd_q[lk_idx];
  assign lk_fault_wr_o = lk_hit && fwr_q[lk_idx];
  assign lk_global_o   = lk_hit && glb_q[lk_idx];

  assign idx_ptr_o   = ptr;
  assign idx_valid_o = vld_q[ptr];
  assign idx_vpn_o   = tag_q[ptr];
  assign idx_ppn_o   = ppn_q[ptr];

  assert_ins_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && flush_op_i != 2'd1) |=>
      idx_ptr_o == (($past(idx_ptr_o) == IDX_W'(DEPTH - 1)) ? '0 : $past(idx_ptr_o) + 1'b1));

  assert_flush_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_op_i == 2'd1) |=> (!lk_hit_o && idx_ptr_o == '0));

  assert_flush_proc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_op_i == 2'd2 && !ins_valid_i) |=> (!lk_hit_o || lk_global_o));

  assert_flush_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_op_i == 2'd3 && !ins_valid_i) |=>
      !(lk_hit_o && lk_vpn_i == $past(flush_vpn_i) &&
        (lk_global_o || lk_asn_i == $past(flush_asn_i))));
endmodule

// File: tb/tb_tlb_assoc.sv
`timescale 1ns/1ps
module tb_tlb_assoc;
  localparam int DEPTH = 48, VPN_W = 30, OFS_W = 13, PPN_W = 27, ASN_W = 8, MODE_N = 4;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int VA_W = VPN_W + OFS_W;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [VPN_W-1:0] lk_vpn = '0;
  logic [ASN_W-1:0] lk_asn = '0;
  logic lk_hit, lk_frd, lk_fwr, lk_glb;
  logic [IDX_W-1:0] lk_idx, idx_ptr;
  logic [PPN_W-1:0] lk_ppn, idx_ppn;
  logic [MODE_N-1:0] lk_ren, lk_wen;
  logic ins_v = 0, ins_g = 0, ins_frd = 0, ins_fwr = 0, adv = 0;
  logic [VA_W-1:0] ins_va = '0;
  logic [PPN_W-1:0] ins_ppn = '0;
  logic [ASN_W-1:0] ins_asn = '0, fl_asn = '0;
  logic [MODE_N-1:0] ins_ren = '0, ins_wen = '0;
  logic [1:0] fl_op = 2'd0;
  logic [VPN_W-1:0] fl_vpn = '0, idx_vpn;
  logic idx_valid;

  tlb_assoc dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_vpn_i(lk_vpn), .lk_asn_i(lk_asn), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx),
    .lk_ppn_o(lk_ppn), .lk_rd_en_o(lk_ren), .lk_wr_en_o(lk_wen),
    .lk_fault_rd_o(lk_frd), .lk_fault_wr_o(lk_fwr), .lk_global_o(lk_glb),
    .ins_valid_i(ins_v), .ins_vaddr_i(ins_va), .ins_ppn_i(ins_ppn), .ins_asn_i(ins_asn),
    .ins_global_i(ins_g), .ins_rd_en_i(ins_ren), .ins_wr_en_i(ins_wen),
    .ins_fault_rd_i(ins_frd), .ins_fault_wr_i(ins_fwr),
    .flush_op_i(fl_op), .flush_vpn_i(fl_vpn), .flush_asn_i(fl_asn),
    .idx_adv_i(adv), .idx_ptr_o(idx_ptr), .idx_valid_o(idx_valid),
    .idx_vpn_o(idx_vpn), .idx_ppn_o(idx_ppn)
  );

  int checks = 0, failures = 0;
  bit m_vld [DEPTH];
  bit m_glb [DEPTH];
  logic [VPN_W-1:0] m_tag [DEPTH];
  logic [ASN_W-1:0] m_asn [DEPTH];
  logic [PPN_W-1:0] m_ppn [DEPTH];
  int m_ptr = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_tag[i] == v && (m_glb[i] || m_asn[i] == a)) return i;
    return -1;
  endfunction

  function automatic bit m_conflict(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, bit g);
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_tag[i] == v && (g || m_glb[i] || m_asn[i] == a)) return 1;
    return 0;
  endfunction

  task automatic tick(bit ins, logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic [ASN_W-1:0] a,
                      bit g, bit ad, logic [1:0] fop, logic [VPN_W-1:0] fv, logic [ASN_W-1:0] fa);
    ins_v = ins; ins_va = {v, OFS_W'(13'h1abc)}; ins_ppn = p; ins_asn = a; ins_g = g;
    ins_ren = 4'b0011; ins_wen = 4'b0001; ins_frd = 1; ins_fwr = 0;
    adv = ad; fl_op = fop; fl_vpn = fv; fl_asn = fa;
    if (fop == 2'd1) begin
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
      m_ptr = 0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fop == 2'd2 && !m_glb[i]) m_vld[i] = 0;
        if (fop == 2'd3 && m_vld[i] && m_tag[i] == fv && (m_glb[i] || m_asn[i] == fa)) m_vld[i] = 0;
      end
      if (ins) begin
        m_vld[m_ptr] = 1; m_tag[m_ptr] = v; m_ppn[m_ptr] = p;
        m_asn[m_ptr] = a; m_glb[m_ptr] = g;
      end
      if (ins || ad) m_ptr = (m_ptr + 1) % DEPTH;
    end
    @(posedge clk); #1;
    ins_v = 0; adv = 0; fl_op = 2'd0;
  endtask

  task automatic ins1(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic [ASN_W-1:0] a, bit g);
    tick(1, v, p, a, g, 0, 2'd0, '0, '0);
  endtask

  task automatic flush(logic [1:0] fop, logic [VPN_W-1:0] fv, logic [ASN_W-1:0] fa);
    tick(0, '0, '0, '0, 0, 0, fop, fv, fa);
  endtask

  task automatic look(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, string req);
    int e;
    lk_vpn = v; lk_asn = a; #1;
    e = m_find(v, a);
    chk(lk_hit == (e >= 0), req, lk_hit, e >= 0);
    if (e >= 0) begin
      chk(lk_idx == IDX_W'(e), req, lk_idx, e);
      chk(lk_ppn == m_ppn[e], req, lk_ppn, m_ppn[e]);
    end else chk(lk_ppn == '0, req, lk_ppn, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240511));
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    look(30'h100, 8'd1, "R1");
    chk(idx_ptr == 0, "R1", idx_ptr, 0);

    // R2, R3 basic insert and hit rule
    ins1(30'h100, 27'h55, 8'd1, 0);
    chk(idx_ptr == 1, "R3", idx_ptr, 1);
    look(30'h100, 8'd1, "R2");
    chk(lk_ren == 4'b0011 && lk_wen == 4'b0001, "R2", {lk_ren, lk_wen}, 8'h31);
    chk(lk_frd && !lk_fwr && !lk_glb, "R2", {lk_frd, lk_fwr, lk_glb}, 3'b100);
    look(30'h100, 8'd2, "R2");
    look(30'h101, 8'd1, "R2");
    ins1(30'h200, 27'h66, 8'd0, 1);
    look(30'h200, 8'd3, "R2");
    chk(lk_glb == 1'b1, "R2", lk_glb, 1);

    // R9 duplicates: lowest index wins
    ins1(30'h300, 27'h77, 8'd1, 0);
    ins1(30'h300, 27'h78, 8'd1, 0);
    look(30'h300, 8'd1, "R9");
    chk(lk_idx == 2 && lk_ppn == 27'h77, "R9", lk_idx, 2);

    // R7 address flush
    flush(2'd3, 30'h100, 8'd2);
    look(30'h100, 8'd1, "R7");
    flush(2'd3, 30'h300, 8'd1);
    look(30'h300, 8'd1, "R7");
    flush(2'd3, 30'h200, 8'd2);
    look(30'h200, 8'd0, "R7");
    look(30'h100, 8'd1, "R7");

    // R6 process flush
    ins1(30'h400, 27'h11, 8'd2, 0);
    ins1(30'h500, 27'h22, 8'd0, 1);
    flush(2'd2, '0, '0);
    look(30'h400, 8'd2, "R6");
    look(30'h500, 8'd7, "R6");
    look(30'h100, 8'd1, "R6");

    // R8 index port
    chk(idx_ptr == 6 && !idx_valid, "R8", {idx_ptr, idx_valid}, 12);
    tick(0, '0, '0, '0, 0, 1, 2'd0, '0, '0);
    chk(idx_ptr == 7, "R8", idx_ptr, 7);
    tick(1, 30'h700, 27'h33, 8'd0, 0, 1, 2'd0, '0, '0);
    chk(idx_ptr == 8, "R8", idx_ptr, 8);
    look(30'h700, 8'd0, "R8");

    // R4 wrap at depth 48
    for (int k = 0; k < 39; k++) ins1(30'h1000 + 30'(k), 27'h100 + 27'(k), 8'd0, 0);
    chk(idx_ptr == 47, "R4", idx_ptr, 47);
    ins1(30'h1027, 27'h127, 8'd0, 0);
    chk(idx_ptr == 0, "R4", idx_ptr, 0);
    for (int k = 0; k < 5; k++) ins1(30'h2000 + 30'(k), 27'h200 + 27'(k), 8'd0, 0);
    chk(idx_valid && idx_vpn == 30'h500 && idx_ppn == 27'h22, "R8", idx_vpn, 30'h500);
    // R3 overwrite of a valid victim
    ins1(30'h600, 27'h44, 8'd0, 0);
    look(30'h500, 8'd0, "R3");
    look(30'h600, 8'd0, "R3");

    // R5 flush-all overrides a concurrent insert
    tick(1, 30'h900, 27'h99, 8'd0, 1, 1, 2'd1, '0, '0);
    chk(idx_ptr == 0, "R5", idx_ptr, 0);
    look(30'h900, 8'd0, "R5");
    look(30'h600, 8'd0, "R5");
    look(30'h2000, 8'd0, "R5");

    // random mix against model
    for (int n = 0; n < 2000; n++) begin
      int r;
      logic [VPN_W-1:0] v;
      logic [ASN_W-1:0] a;
      bit g;
      r = $urandom_range(0, 99);
      v = 30'h3000 + 30'($urandom_range(0, 40));
      a = ASN_W'($urandom_range(0, 3));
      g = ($urandom_range(0, 4) == 0);
      if (r < 45) begin
        if (!m_conflict(v, a, g)) ins1(v, 27'($urandom), a, g);
        else tick(0, '0, '0, '0, 0, 0, 2'd0, '0, '0);
      end else if (r < 55) tick(0, '0, '0, '0, 0, 1, 2'd0, '0, '0);
      else if (r < 60) flush(2'd2, '0, '0);
      else if (r < 70) flush(2'd3, v, a);
      else if (r < 72) flush(2'd1, '0, '0);
      else tick(0, '0, '0, '0, 0, 0, 2'd0, '0, '0);
      look(30'h3000 + 30'($urandom_range(0, 40)), ASN_W'($urandom_range(0, 3)), "R2");
      look(v, a, "R9");
      chk(idx_ptr == IDX_W'(m_ptr), "R3", idx_ptr, m_ptr);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule